// File: doc/BRIEF.md
# Periodic Interval Timer with Missed-Period Count

This block is a periodic interval timer behind a byte-wide register bus. A divided clock tick advances a 16-bit up-counter. When the counter has reached the programmed limit, the next tick returns it to zero. That tick also adds one to a small saturating count of completed periods and raises an interrupt request. If an interrupt service routine runs late, it reads that count and replays every period it missed. It then issues a start command, which empties the count and leaves the counter running.

The register bus is a plain control interface with no handshake. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Reading the running count does not latch or pause anything. The count and the overflow field therefore cannot be captured together. Software reads the count twice and treats a smaller second value as a wrap between the reads.

The register map is:

| Address | Register | Access |
|---|---|---|
| 0 | limit, high byte | staged on write |
| 1 | limit, low byte | commits the 16-bit limit on write |
| 2 | running count, high byte | read only |
| 3 | running count, low byte | read only |
| 4 | control | read and write |
| 5 | interrupt control | read and write |

Top module: `ptimer_top`

## Requirements
- R1: After reset the block is in a known idle state:
  - the timer is stopped, and the count and overflow field are zero;
  - interrupt control reads 0x00;
  - `irq_req` is low.
- R2: The 16-bit limit is written as one access.
  - A write to address 0 only stages the high byte. The committed value is unchanged, and address 0 reads back the committed high byte.
  - A write to address 1 commits the staged high byte together with the written low byte.
- R3: While running, the count rises by one every PRESCALE clock cycles. While stopped, it holds. It is read as high byte (address 2) and low byte (address 3).
- R4: A tick that finds the count equal to the active limit does three things: it sets the count to 0, adds one to the overflow field, and sets the pending flag. One period is therefore limit+1 ticks.
- R5: The overflow field is control bits [7:4]. It saturates at 15 and never wraps.
- R6: Control reads back as {overflow[3:0], 2'b00, running, 1'b0}. A control write with bit 1 = 0 is the clear command. Clear stops the timer, zeroes the count, the overflow field and the prescaler, and copies the committed limit into the active limit.
- R7: A control write with bit 1 = 1 is the start command.
  - From the stopped state, the timer runs from zero.
  - While running, start zeroes the overflow field and leaves the count running undisturbed.
- R8: A limit committed while the timer runs has no effect on the active period until the next clear. It takes effect on the start that follows that clear.
- R9: Interrupt control is laid out as follows:
  - bits [2:0] hold the level and bit 4 holds the enable;
  - writing bit 3 as 1 clears the pending flag (a wrap on the same edge wins);
  - reads return {pending, 2'b00, enable, 1'b0, level}.
- R10: `irq_req` is high exactly while pending and enable are both 1, and `irq_level` shows the stored level. Writing 0x00 to interrupt control drops `irq_req` and keeps the pending flag. The count keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt level |

## Verification
The assertions take for granted that each high cycle of `bus_we` is one deliberate register write. They also assume a control write and a timer wrap on the same edge are resolved as the requirements state. For example, a start that meets a wrap does not leave the overflow field at zero, so the start check excludes that edge.

The stimulus drives every write for exactly one cycle, in the low clock phase. Commands are timed from the start edge, so they never coincide with a wrap except where a test intends it. Reads are sampled a fraction of a nanosecond after the falling edge. All expected counts then follow from the PRESCALE spacing of ticks after the start edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Fixed bus layout: count and limit are 16 bits, split into two bytes.
  localparam int CNT_W = 16;
  localparam int OVF_W = 4;
  localparam int LVL_W = 3;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] A_LIM_HI = 3'd0;
  localparam logic [ADR_W-1:0] A_LIM_LO = 3'd1;
  localparam logic [ADR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADR_W-1:0] A_CNT_LO = 3'd3;
  localparam logic [ADR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADR_W-1:0] A_ICTL   = 3'd5;

  localparam int CTRL_RUN_BIT = 1;
  localparam int ICTL_ACK_BIT = 3;
  localparam int ICTL_EN_BIT  = 4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] pc;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pc <= '0;
        else if (!run)                   pc <= '0;
        else if (pc == PW'(DIV - 1))     pc <= '0;
        else                             pc <= pc + 1'b1;
      end

      assign tick = run && (pc == PW'(DIV - 1));

      // R3: ticks are spaced PRESCALE cycles apart, so never back to back
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_cmd,
  input  logic             start_cmd,
  input  logic [CNT_W-1:0] limit_new,
  output logic [CNT_W-1:0] count,
  output logic [OVF_W-1:0] ovf,
  output logic             running,
  output logic             wrap
);
  logic [CNT_W-1:0] limit_act;
  logic [OVF_W-1:0] ovf_base;

  assign wrap = tick && (count == limit_act);

  // A start command empties the overflow field before any wrap is added.
  assign ovf_base = start_cmd ? '0 : ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      count     <= '0;
      ovf       <= '0;
      limit_act <= '0;
    end else if (clr_cmd) begin
      running   <= 1'b0;
      count     <= '0;
      ovf       <= '0;
      limit_act <= limit_new;
    end else begin
      if (start_cmd) running <= 1'b1;
      if (wrap) begin
        count <= '0;
        ovf   <= (ovf_base == '1) ? ovf_base : ovf_base + 1'b1;
      end else begin
        if (tick) count <= count + 1'b1;
        ovf <= ovf_base;
      end
    end
  end

  assert_count_le_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit_act);
  assert_ovf_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == '1) && !clr_cmd && !start_cmd |=> ovf == '1);
  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start_cmd |=> $stable(count));
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (count == '0) && (ovf == '0) && !running);
  assert_start_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd && !clr_cmd && !wrap |=> ovf == '0);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ictl,
  input  logic [7:0]       wdata,
  input  logic             wrap,
  output logic [LVL_W-1:0] level,
  output logic             enable,
  output logic             pending,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      enable  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wr_ictl) begin
        level  <= wdata[LVL_W-1:0];
        enable <= wdata[ICTL_EN_BIT];
      end
      if (wrap)                                   pending <= 1'b1;
      else if (wr_ictl && wdata[ICTL_ACK_BIT])    pending <= 1'b0;
    end
  end

  assign irq = pending && enable;

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ictl && wdata[ICTL_ACK_BIT] && !wrap |=> !pending);
  assert_wrap_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pending);
  assert_zero_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ictl && (wdata == 8'h00) |=> !irq);
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic [CNT_W-1:0] limit_reg;
  logic [7:0]       limit_hi_stage;
  logic [CNT_W-1:0] count;
  logic [OVF_W-1:0] ovf;
  logic             running, wrap, tick;
  logic             clr_cmd, start_cmd, wr_ictl;
  logic             enable, pending;

  assign clr_cmd   = bus_we && (bus_addr == A_CTRL) && !bus_wdata[CTRL_RUN_BIT];
  assign start_cmd = bus_we && (bus_addr == A_CTRL) &&  bus_wdata[CTRL_RUN_BIT];
  assign wr_ictl   = bus_we && (bus_addr == A_ICTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_hi_stage <= '0;
      limit_reg      <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_LIM_HI) limit_hi_stage <= bus_wdata;
      if (bus_addr == A_LIM_LO) limit_reg      <= {limit_hi_stage, bus_wdata};
    end
  end

  tmr_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
  );

  tmr_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr_cmd(clr_cmd),
    .start_cmd(start_cmd), .limit_new(limit_reg), .count(count),
    .ovf(ovf), .running(running), .wrap(wrap)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_ictl(wr_ictl), .wdata(bus_wdata),
    .wrap(wrap), .level(irq_level), .enable(enable), .pending(pending),
    .irq(irq_req)
  );

  always_comb begin
    case (bus_addr)
      A_LIM_HI: bus_rdata = limit_reg[15:8];
      A_LIM_LO: bus_rdata = limit_reg[7:0];
      A_CNT_HI: bus_rdata = count[15:8];
      A_CNT_LO: bus_rdata = count[7:0];
      A_CTRL:   bus_rdata = {ovf, 2'b00, running, 1'b0};
      A_ICTL:   bus_rdata = {pending, 2'b00, enable, 1'b0, irq_level};
      default:  bus_rdata = 8'h00;
    endcase
  end

  // R2: staging the high byte leaves the committed limit untouched
  assert_limit_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && (bus_addr == A_LIM_HI) |=> $stable(limit_reg));
endmodule

// File: tb/sim_ptimer_top.sv
`timescale 1ns/100ps
module sim_ptimer_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [2:0] irq_level;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptimer_top #(.PRESCALE(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_level(irq_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one idle edge, then the write edge; returns just after the following falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd3, d); chk("R1 count lo", d, 8'h00);
    rd(3'd4, d); chk("R1 control", d, 8'h00);
    rd(3'd5, d); chk("R1 intctl", d, 8'h00);
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_limit_stage();
    logic [7:0] d;
    wr(3'd0, 8'h12);
    rd(3'd0, d); chk("R2 hi staged only", d, 8'h00);
    wr(3'd1, 8'h34);
    rd(3'd0, d); chk("R2 hi committed", d, 8'h12);
    rd(3'd1, d); chk("R2 lo committed", d, 8'h34);
  endtask

  task automatic t_count_wrap();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h09);
    wr(3'd4, 8'h00); wr(3'd4, 8'h02);     // clear, then start from zero
    wait_edges(20);
    rd(3'd3, d); chk("R3 R7 count after 5 ticks", d, 5);
    rd(3'd2, d); chk("R3 count hi", d, 0);
    wait_edges(24);                        // 11 ticks: wrap at tick 10
    rd(3'd3, d); chk("R4 count after wrap", d, 1);
    rd(3'd4, d); chk("R4 R6 overflow 1 running", d, 8'h12);
    rd(3'd5, d); chk("R4 R9 pending set", d, 8'h80);
    chk("R10 irq low while disabled", irq_req, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(3'd5, 8'h15);
    chk("R10 irq with enable", irq_req, 1);
    chk("R10 level out", irq_level, 5);
    wr(3'd5, 8'h1D);                       // acknowledge
    chk("R9 irq after ack", irq_req, 0);
    rd(3'd5, d); chk("R9 ack clears pending", d, 8'h15);
  endtask

  task automatic t_zero_disable();
    logic [7:0] d, c1, c2;
    wait_edges(40);                        // next wrap happens in this window
    chk("R10 irq on second wrap", irq_req, 1);
    wr(3'd5, 8'h00);
    chk("R10 irq dropped by zero write", irq_req, 0);
    rd(3'd5, d); chk("R10 pending kept", d, 8'h80);
    rd(3'd3, c1);
    wait_edges(8);
    rd(3'd3, c2);
    chk("R10 count still advancing", (c1 != c2) ? 1 : 0, 1);
  endtask

  task automatic t_new_limit();
    logic [7:0] d;
    bit seen_big = 1'b0;
    wr(3'd0, 8'h00); wr(3'd1, 8'h03);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rd(3'd3, d);
      if (d > 3) seen_big = 1'b1;
    end
    chk("R8 old limit still active", seen_big, 1);
    wr(3'd4, 8'h00); wr(3'd4, 8'h02);
    wait_edges(16);                        // 4 ticks = one period of limit 3
    rd(3'd3, d); chk("R8 new limit wraps", d, 0);
    rd(3'd4, d); chk("R8 overflow after new period", d, 8'h12);
    wait_edges(24);                        // 10 ticks total
    rd(3'd3, d); chk("R4 count at tick 10", d, 2);
    rd(3'd4, d); chk("R4 overflow two", d, 8'h22);
    wr(3'd4, 8'h02);                       // start while running
    rd(3'd3, d); chk("R7 count kept on restart", d, 2);
    rd(3'd4, d); chk("R7 overflow zeroed", d, 8'h02);
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd4, 8'h00); wr(3'd4, 8'h02);
    wait_edges(100);                       // 25 wraps
    rd(3'd4, d); chk("R5 overflow saturates", d, 8'hF2);
    rd(3'd3, d); chk("R5 count at limit 0", d, 0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R6 clear control", d, 8'h00);
    wait_edges(20);
    rd(3'd3, d); chk("R6 R3 count held", d, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_limit_stage();
    t_count_wrap();
    t_irq();
    t_zero_disable();
    t_new_limit();
    t_saturate();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule